// File: doc/BRIEF.md
# SAR conversion and acquisition sequencer

This block is the digital controller of a successive-approximation converter. A behavioural capacitor array and comparator sit outside it. Before the first conversion the block runs a calibration wait. It then tracks the input with a fixed coarse-charge phase, followed by a fine-charge phase. While fine charge is running, an active-low hold request starts a conversion. The conversion lasts a fixed number of master clocks. During it, the block drives a trial code toward the DAC and resolves one bit per clock, from the most significant bit down.

When a conversion ends, the block raises a one-cycle done strobe and stores the final code in a result register for a downstream serial port. It then goes back to coarse charge. When both mode-select inputs are low, the block runs on its own internal frame timer and ignores the hold input. A coarse-request input lets the system hold off fine charge while it tracks high-slew signals. A channel select picks which of two track status outputs shows the tracking phase.

Top module: `sar_seq_top`

## Requirements
- R1: While `rst_n` is low, `stby_n` is low. After release, `stby_n` stays low for CAL_CLKS clocks, then rises at the same time as `coarse_chg`. Calibration is never re-entered without a reset.
- R2: `hold_n` is sampled on the falling clock edge. A low sample taken during fine charge starts a conversion on the next rising edge. From that edge on, `dac_code` is 0x8000, and `trk`, `coarse_chg` and `fine_chg` are all 0.
- R3: Bits resolve MSB first, one per clock. At each clock, the bit on trial is kept when `cmp_keep` is 1 (analog input at or above `dac_code`) and cleared when it is 0. In the same clock the next lower bit is set as the new trial. After 16 steps `dac_code` holds the final code.
- R4: A conversion occupies CONV_CLKS (65) clocks. On its last clock `done` pulses high for one cycle and `result` takes the final code. `result` changes at no other time.
- R5: Each conversion is followed by exactly COARSE_CLKS (6) clocks of `coarse_chg`, then `fine_chg`, as long as `crs_req` is low.
- R6: `crs_req` high keeps the block in coarse charge past the six clocks. `crs_req` high during fine charge returns the block to coarse charge and restarts the six-clock count. This can be repeated any number of times.
- R7: With `mode_sel` = 2'b00 (free-run), `hold_n` has no effect. A conversion starts every FRAME_CLKS (80) clocks, which leaves 9 clocks of fine charge per frame.
- R8: In any other mode, if `hold_n` stays low, a new conversion starts on the first fine-charge clock after each coarse phase. `done` then repeats every 72 clocks.
- R9: `trk[i]` is 1 only while tracking (coarse or fine charge) and `ch_sel` equals i. Both bits are 0 during calibration and conversion.
- R10: A hold request that is sampled low only during coarse charge starts no conversion. The block passes into fine charge and keeps tracking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset; starts calibration |
| hold_n | input | 1 | Active-low conversion request, sampled on the falling edge |
| mode_sel | input | 2 | 2'b00 selects free-run; other values select hold-triggered operation |
| crs_req | input | 1 | Coarse-charge request |
| ch_sel | input | 1 | Channel to track (0 or 1) |
| cmp_keep | input | 1 | Comparator decision for the current trial code |
| stby_n | output | 1 | Low during calibration |
| coarse_chg | output | 1 | Coarse-charge phase active |
| fine_chg | output | 1 | Fine-charge phase active |
| trk | output | 2 | Per-channel track status |
| dac_code | output | 16 | Trial code toward the DAC |
| done | output | 1 | One-cycle end-of-conversion strobe |
| result | output | 16 | Last converted code |

## Verification
Two events can land on the same clock:
- A hold request and the closing cycles of the coarse phase. The bench lowers `hold_n` mid-coarse, and also holds it low across the end of a conversion.
- A coarse request and the first fine-charge cycle, where a start could also be decided.

In each case a behavioural model in the bench predicts the phase, the strobe and the trial code for every clock. Done-to-done spacing is measured as 72 clocks with hold held low and 80 clocks in free-run. A hold pulse seen only in coarse charge must leave the block tracking.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
   typedef enum logic [1:0] {
      PH_CAL    = 2'd0,
      PH_CONV   = 2'd1,
      PH_COARSE = 2'd2,
      PH_FINE   = 2'd3
   } sar_phase_e;
endpackage

// File: rtl/sar_hold_latch.sv
module sar_hold_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic hold_n,
   output logic hold_lat
);
   // request is captured on the falling edge, half a cycle ahead of the phase logic
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) hold_lat <= 1'b1;
      else        hold_lat <= hold_n;
   end
endmodule

// File: rtl/sar_phase_fsm.sv
module sar_phase_fsm
   import sar_seq_pkg::*;
#(
   parameter int CONV_CLKS   = 65,
   parameter int COARSE_CLKS = 6,
   parameter int FRAME_CLKS  = 80,
   parameter int CAL_CLKS    = 11528160
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       hold_lat,
   input  logic       free_run,
   input  logic       crs_req,
   output sar_phase_e phase,
   output logic       start,
   output logic       conv_last,
   output logic       done
);
   localparam int FR_FINE = FRAME_CLKS - CONV_CLKS - COARSE_CLKS;
   localparam int CNT_W   = $clog2(CAL_CLKS + FRAME_CLKS + 1);
   localparam logic [CNT_W-1:0] CAL_LAST    = CNT_W'(CAL_CLKS - 1);
   localparam logic [CNT_W-1:0] CONV_LAST   = CNT_W'(CONV_CLKS - 1);
   localparam logic [CNT_W-1:0] COARSE_LAST = CNT_W'(COARSE_CLKS - 1);
   localparam logic [CNT_W-1:0] FINE_LAST   = CNT_W'(FR_FINE - 1);

   sar_phase_e       ph_q, ph_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;

   assign phase     = ph_q;
   assign conv_last = (ph_q == PH_CONV) && (cnt_q == CONV_LAST);
   assign start     = (ph_q == PH_FINE) &&
                      (free_run ? (cnt_q >= FINE_LAST) : !hold_lat);

   always_comb begin
      ph_d  = ph_q;
      cnt_d = cnt_q;
      unique case (ph_q)
         PH_CAL: begin
            if (cnt_q == CAL_LAST) begin
               ph_d  = PH_COARSE;
               cnt_d = '0;
            end else begin
               cnt_d = cnt_q + 1'b1;
            end
         end
         PH_CONV: begin
            if (conv_last) begin
               ph_d  = PH_COARSE;
               cnt_d = '0;
            end else begin
               cnt_d = cnt_q + 1'b1;
            end
         end
         PH_COARSE: begin
            if ((cnt_q >= COARSE_LAST) && !crs_req) begin
               ph_d  = PH_FINE;
               cnt_d = '0;
            end else if (cnt_q < COARSE_LAST) begin
               cnt_d = cnt_q + 1'b1;
            end
         end
         PH_FINE: begin
            if (start) begin
               ph_d  = PH_CONV;
               cnt_d = '0;
            end else if (crs_req) begin
               ph_d  = PH_COARSE;
               cnt_d = '0;
            end else if (cnt_q < FINE_LAST) begin
               cnt_d = cnt_q + 1'b1;
            end
         end
         default: begin
            ph_d  = PH_CAL;
            cnt_d = '0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q  <= PH_CAL;
         cnt_q <= '0;
         done  <= 1'b0;
      end else begin
         ph_q  <= ph_d;
         cnt_q <= cnt_d;
         done  <= conv_last;
      end
   end

   // R4
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R1
   no_recal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q != PH_CAL) |=> (ph_q != PH_CAL));
   // R5
   coarse_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q == PH_COARSE && cnt_q < COARSE_LAST) |=> (ph_q == PH_COARSE));
   // R2
   conv_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ph_q == PH_CONV) |-> ($past(ph_q) == PH_FINE));
endmodule

// File: rtl/sar_approx_reg.sv
module sar_approx_reg #(
   parameter int NBITS = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             conv_act,
   input  logic             conv_last,
   input  logic             cmp_keep,
   output logic [NBITS-1:0] dac_code,
   output logic [NBITS-1:0] result
);
   localparam logic [NBITS-1:0] MSB_ONLY = {1'b1, {(NBITS-1){1'b0}}};

   logic [NBITS-1:0] ptr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dac_code <= '0;
         ptr_q    <= '0;
         result   <= '0;
      end else begin
         if (start) begin
            dac_code <= MSB_ONLY;
            ptr_q    <= MSB_ONLY;
         end else if (conv_act) begin
            dac_code <= (dac_code & ~ptr_q) | (cmp_keep ? ptr_q : '0) | (ptr_q >> 1);
            ptr_q    <= ptr_q >> 1;
         end
         if (conv_last) result <= dac_code;
      end
   end

   // R3
   ptr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ptr_q));
   // R4
   result_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !conv_last |=> $stable(result));
endmodule

// File: rtl/sar_track_out.sv
module sar_track_out
   import sar_seq_pkg::*;
#(
   parameter int NCH = 2,
   localparam int SEL_W = (NCH > 1) ? $clog2(NCH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  sar_phase_e       phase,
   input  logic [SEL_W-1:0] ch_sel,
   output logic [NCH-1:0]   trk
);
   logic tracking;
   assign tracking = (phase == PH_COARSE) || (phase == PH_FINE);

   generate
      if (NCH == 1) begin : g_single
         assign trk[0] = tracking;
      end else begin : g_multi
         for (genvar i = 0; i < NCH; i++) begin : g_ch
            assign trk[i] = tracking && (ch_sel == SEL_W'(i));
         end
      end
   endgenerate

   // R9
   trk_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(trk));
   // R9
   trk_conv_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_CONV || phase == PH_CAL) |-> (trk == '0));
endmodule

// File: rtl/sar_seq_top.sv
module sar_seq_top
   import sar_seq_pkg::*;
#(
   parameter int NBITS       = 16,
   parameter int NCH         = 2,
   parameter int CONV_CLKS   = 65,
   parameter int COARSE_CLKS = 6,
   parameter int FRAME_CLKS  = 80,
   parameter int CAL_CLKS    = 11528160,
   localparam int SEL_W      = (NCH > 1) ? $clog2(NCH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hold_n,
   input  logic [1:0]       mode_sel,
   input  logic             crs_req,
   input  logic [SEL_W-1:0] ch_sel,
   input  logic             cmp_keep,
   output logic             stby_n,
   output logic             coarse_chg,
   output logic             fine_chg,
   output logic [NCH-1:0]   trk,
   output logic [NBITS-1:0] dac_code,
   output logic             done,
   output logic [NBITS-1:0] result
);
   initial begin
      assert (NBITS >= 2) else $error("NBITS must be at least 2");
      assert (CONV_CLKS > NBITS) else $error("CONV_CLKS must exceed NBITS");
      assert (COARSE_CLKS >= 1) else $error("COARSE_CLKS must be positive");
      assert (FRAME_CLKS > CONV_CLKS + COARSE_CLKS) else $error("frame leaves no fine charge");
      assert (CAL_CLKS >= 1) else $error("CAL_CLKS must be positive");
   end

   logic       hold_lat;
   sar_phase_e phase;
   logic       start;
   logic       conv_last;

   sar_hold_latch u_hold (
      .clk      (clk),
      .rst_n    (rst_n),
      .hold_n   (hold_n),
      .hold_lat (hold_lat)
   );

   sar_phase_fsm #(
      .CONV_CLKS   (CONV_CLKS),
      .COARSE_CLKS (COARSE_CLKS),
      .FRAME_CLKS  (FRAME_CLKS),
      .CAL_CLKS    (CAL_CLKS)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .hold_lat  (hold_lat),
      .free_run  (mode_sel == 2'b00),
      .crs_req   (crs_req),
      .phase     (phase),
      .start     (start),
      .conv_last (conv_last),
      .done      (done)
   );

   sar_approx_reg #(.NBITS(NBITS)) u_sar (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .conv_act  (phase == PH_CONV),
      .conv_last (conv_last),
      .cmp_keep  (cmp_keep),
      .dac_code  (dac_code),
      .result    (result)
   );

   sar_track_out #(.NCH(NCH)) u_trk (
      .clk    (clk),
      .rst_n  (rst_n),
      .phase  (phase),
      .ch_sel (ch_sel),
      .trk    (trk)
   );

   assign stby_n     = (phase != PH_CAL);
   assign coarse_chg = (phase == PH_COARSE);
   assign fine_chg   = (phase == PH_FINE);
endmodule

// File: tb/sar_seq_top_bench.sv
module sar_seq_top_bench;
   localparam int N      = 16;
   localparam int CAL_N  = 40;
   localparam int CONV_N = 65;
   localparam int CRS_N  = 6;
   localparam int FR_N   = 80;
   localparam int FINE_N = FR_N - CONV_N - CRS_N;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        hold_n = 1'b1;
   logic [1:0]  mode_sel = 2'b01;
   logic        crs_req = 1'b0;
   logic [0:0]  ch_sel = 1'b0;
   logic [15:0] vin = 16'h0000;
   logic        cmp_keep;
   logic        stby_n, coarse_chg, fine_chg, done;
   logic [1:0]  trk;
   logic [15:0] dac_code, result;

   assign cmp_keep = (vin >= dac_code);

   always #10 clk = ~clk;

   sar_seq_top #(.CAL_CLKS(CAL_N)) u_sar_seq_top (
      .clk(clk), .rst_n(rst_n), .hold_n(hold_n), .mode_sel(mode_sel),
      .crs_req(crs_req), .ch_sel(ch_sel), .cmp_keep(cmp_keep),
      .stby_n(stby_n), .coarse_chg(coarse_chg), .fine_chg(fine_chg),
      .trk(trk), .dac_code(dac_code), .done(done), .result(result)
   );

   int n_cmp = 0;
   int n_bad = 0;
   int cyc = 0;
   int dq[$];

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cyc);
      end
   endtask

   // behavioural reference: 0 cal, 1 conv, 2 coarse, 3 fine
   int          m_ph;
   int          m_cnt;
   logic        m_hold;
   logic        e_done;
   logic [15:0] e_dac, e_res;

   function automatic logic [15:0] top_bits(input logic [15:0] v, input int k);
      int mask;
      mask = ((1 << N) - 1) & ~((1 << (N - k)) - 1);
      return v & mask[15:0];
   endfunction

   always @(negedge clk or negedge rst_n)
      if (!rst_n) m_hold <= 1'b1; else m_hold <= hold_n;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_ph = 0; m_cnt = 0; e_done = 0; e_dac = '0; e_res = '0;
      end else begin
         e_done = 0;
         case (m_ph)
            0: if (m_cnt == CAL_N - 1) begin m_ph = 2; m_cnt = 0; end else m_cnt++;
            1: begin
               if (m_cnt == CONV_N - 1) begin
                  m_ph = 2; m_cnt = 0; e_done = 1; e_res = vin;
               end else begin
                  m_cnt++;
                  if (m_cnt < N) e_dac = top_bits(vin, m_cnt) | (16'h1 << (N - 1 - m_cnt));
                  else e_dac = vin;
               end
            end
            2: if (m_cnt >= CRS_N - 1 && !crs_req) begin m_ph = 3; m_cnt = 0; end
               else if (m_cnt < CRS_N - 1) m_cnt++;
            default: begin
               if ((mode_sel == 2'b00) ? (m_cnt >= FINE_N - 1) : !m_hold) begin
                  m_ph = 1; m_cnt = 0; e_dac = 16'h8000;
               end else if (crs_req) begin m_ph = 2; m_cnt = 0; end
               else if (m_cnt < FINE_N - 1) m_cnt++;
            end
         endcase
      end
   end

   // per-clock comparison against the model
   always @(posedge clk) begin
      cyc++;
      #15;
      check(stby_n === (m_ph != 0), "R1 stby_n", stby_n, m_ph != 0);
      check(coarse_chg === (m_ph == 2), "R5 coarse_chg", coarse_chg, m_ph == 2);
      check(fine_chg === (m_ph == 3), "R5 fine_chg", fine_chg, m_ph == 3);
      check(trk === (((m_ph >= 2) ? 2'b01 : 2'b00) << ch_sel), "R9 trk", trk,
            ((m_ph >= 2) ? 2'b01 : 2'b00) << ch_sel);
      check(dac_code === e_dac, "R3 dac_code", dac_code, e_dac);
      check(done === e_done, "R4 done", done, e_done);
      check(result === e_res, "R4 result", result, e_res);
      if (done === 1'b1) dq.push_back(cyc);
   end

   task automatic tick_drive();
      @(posedge clk); #2;
   endtask

   task automatic wait_fine();
      do begin @(posedge clk); #15; end while (fine_chg !== 1'b1);
   endtask

   task automatic wait_done();
      do begin @(posedge clk); #15; end while (done !== 1'b1);
   endtask

   task automatic run_conv(input logic [15:0] v);
      wait_fine();
      vin = v;
      tick_drive(); hold_n = 1'b0;
      tick_drive(); hold_n = 1'b1;
      #13;
      // R2: start on the rising edge after the falling-edge capture
      check(trk === 2'b00 && dac_code === 16'h8000 && !coarse_chg && !fine_chg,
            "R2 start", {trk, dac_code}, 16'h8000);
      wait_done();
      check(result === v, "R4 final code", result, v);
   endtask

   initial begin
      #1;
      check(stby_n === 1'b0 && done === 1'b0 && trk === 2'b00, "R1 reset", stby_n, 0);
      repeat (3) tick_drive();
      rst_n = 1'b1;
      repeat (CAL_N - 2) tick_drive();
      #13;
      check(stby_n === 1'b0, "R1 still calibrating", stby_n, 0);
      repeat (4) @(posedge clk);
      #15;
      check(stby_n === 1'b1, "R1 calibration over", stby_n, 1);

      run_conv(16'hA5C3);
      ch_sel = 1'b1;
      run_conv(16'h0000);
      run_conv(16'hFFFF);
      run_conv(16'h7FFF);

      // R10: hold seen only in coarse charge is dropped
      tick_drive(); hold_n = 1'b0;
      tick_drive(); hold_n = 1'b1;
      repeat (12) @(posedge clk);
      #15;
      check(fine_chg === 1'b1 && trk === 2'b10, "R10 hold in coarse ignored", {fine_chg, trk}, 3'b110);

      // R6: coarse request, repeated
      for (int r = 0; r < 2; r++) begin
         wait_fine();
         tick_drive(); crs_req = 1'b1;
         repeat (10) @(posedge clk);
         #15;
         check(coarse_chg === 1'b1, "R6 coarse held", coarse_chg, 1);
         tick_drive(); crs_req = 1'b0;
         repeat (2) @(posedge clk);
         #15;
         check(fine_chg === 1'b1, "R6 back to fine", fine_chg, 1);
      end

      // R8: hold kept low gives back-to-back conversions
      vin = 16'h3C5A;
      dq.delete();
      tick_drive(); hold_n = 1'b0;
      repeat (300) @(posedge clk);
      #2; hold_n = 1'b1;
      check(dq.size() >= 3, "R8 repeat count", dq.size(), 3);
      for (int i = 1; i < dq.size(); i++)
         check(dq[i] - dq[i-1] == CONV_N + CRS_N + 1, "R8 spacing", dq[i] - dq[i-1], CONV_N + CRS_N + 1);

      // R7: free-run ignores hold, 80-clock frame
      wait_fine();
      vin = 16'h1234;
      tick_drive(); mode_sel = 2'b00;
      repeat (100) @(posedge clk);
      dq.delete();
      #2; hold_n = 1'b0;
      repeat (200) @(posedge clk);
      #2; hold_n = 1'b1;
      repeat (200) @(posedge clk);
      check(dq.size() >= 4, "R7 free-run count", dq.size(), 4);
      for (int i = 1; i < dq.size(); i++)
         check(dq[i] - dq[i-1] == FR_N, "R7 frame", dq[i] - dq[i-1], FR_N);
      wait_fine();
      tick_drive(); mode_sel = 2'b01;

      // R1: reset mid-conversion restarts calibration
      run_conv(16'h0F0F);
      wait_fine();
      tick_drive(); hold_n = 1'b0;
      tick_drive(); hold_n = 1'b1;
      repeat (5) tick_drive();
      rst_n = 1'b0;
      #13;
      check(stby_n === 1'b0 && trk === 2'b00, "R1 reset in conversion", stby_n, 0);
      tick_drive(); rst_n = 1'b1;
      repeat (CAL_N + 4) @(posedge clk);
      #15;
      check(stby_n === 1'b1, "R1 recalibrated", stby_n, 1);
      run_conv(16'h8001);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule